// File: doc/BRIEF.md
# Peripheral Write-Cycle Timing Generator

This block sits on the host side of a small peripheral and turns write requests into correctly timed cycles on a non-multiplexed bus with separate select, direction and strobe lines. A request carries a 3-bit register address, an 8-bit data byte and a 2-bit tag that tells the sequencer which class of register is being written. The request is taken over a valid/ready handshake. The block then drives address, select, direction and data. It pulses the active-low data strobe and keeps the bus stable for the required hold time before it accepts the next request.

Every interval is a nanosecond parameter. Each one is turned into a count of system clocks at elaboration by rounding up. The high time between two strobes has a fixed floor. That floor is raised to a multiple of an arbitration period when the previous access was to the address-pointer-low register, or when a data-register access is followed by an address-pointer-low write. The arbitration period is one operating clock, or two operating clocks when the slow-arbitration input is set.

Top module: `periph_wr_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request, `req_ready_o`=1, `bus_cs_n_o`=1, `bus_ds_n_o`=1 and `bus_dir_o`=0.
- R2: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` then stays 0 until the hold time after the strobe has elapsed. A request held valid during that time stalls and is taken afterwards, with its own address and data.
- R3: From the edge that accepts a request, address, data, `bus_cs_n_o`=0 and `bus_dir_o`=1 (1 means write) are driven. The strobe falls no earlier than 11 clocks later: ceil(max(105,50,10)/10).
- R4: The strobe stays low for exactly 26 clocks, the larger of ceil(260/10) and ceil(30/10).
- R5: `bus_cs_n_o` returns to 1 on the same edge on which the strobe rises. Address, data and `bus_dir_o`=1 are held for 10 more clocks: ceil(max(100,10,10)/10). `req_ready_o` returns to 1 on that same edge.
- R6: The strobe stays high for at least 23 clocks (ceil(230/10)) between two strobes. If the spacing requirement is not otherwise raised, a request offered as soon as ready returns gives a gap of exactly 23.
- R7: After a cycle tagged address-pointer-low (tag 2'b01), the next strobe high time is at least 4 arbitration periods. The arbitration period is 4 clocks when `slow_arb_i`=0 and 8 clocks when it is 1, so the gap is 32 clocks in slow mode.
- R8: A cycle tagged address-pointer-low that follows a cycle tagged data-register (tag 2'b10) has a strobe high time of at least 5 arbitration periods: 40 clocks in slow mode.
- R9: Tags 2'b00 and 2'b11 add no extra spacing, and a data-register cycle followed by any tag other than 2'b01 keeps the 23-clock floor.
- R10: Address and data do not change while `bus_cs_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request present |
| req_ready_o | output | 1 | Sequencer can take a request |
| req_addr_i | input | 3 | Register address of the request |
| req_data_i | input | 8 | Byte to write |
| req_tag_i | input | 2 | Register class: 01 pointer-low, 10 data, 00/11 other |
| slow_arb_i | input | 1 | Arbitration period doubled when 1 |
| bus_addr_o | output | 3 | Bus address |
| bus_cs_n_o | output | 1 | Chip select, active low |
| bus_dir_o | output | 1 | Direction, 1 = write |
| bus_ds_n_o | output | 1 | Data strobe, active low |
| bus_data_o | output | 8 | Bus write data |

## Verification
The assertions check on every cycle that the strobe only falls inside an active select with the direction set to write. They also check that select is released on the rising strobe edge, that the strobe low width and the select-to-strobe lead are met, that the 23-clock high floor is kept, and that address and data stay still under select. The tag-dependent spacing of R7 to R9 depends on the history of register classes and on the slow-arbitration mode, so only the bench's scenarios show it. Those scenarios cover pointer-low followed by other tags, data followed by pointer-low, and spare tags, in both modes. They also cover a request that stalls behind a busy cycle and a request that arrives after a long idle.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    TAG_OTHER  = 2'b00,
    TAG_PTR_LO = 2'b01,
    TAG_DATA   = 2'b10,
    TAG_SPARE  = 2'b11
  } reg_tag_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwr_phase_timer.sv
module pwr_phase_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // counts the current cycle as elapsed
  assign done_o = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, limit_i};

endmodule

// File: rtl/pwr_gap_tracker.sv
module pwr_gap_tracker import pwr_pkg::*; #(
  parameter int unsigned HI_CYC       = 23,
  parameter int unsigned OPR_CYC      = 4,
  parameter int unsigned PTR_ARB      = 4,
  parameter int unsigned DATA_PTR_ARB = 5,
  parameter int unsigned GAP_W        = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ds_low_i,
  input  logic       rise_i,
  input  logic [1:0] cur_tag_i,
  input  logic       slow_arb_i,
  output logic       gap_ok_o
);

  localparam logic [GAP_W-1:0] HiGap       = GAP_W'(HI_CYC);
  localparam logic [GAP_W-1:0] PtrFast     = GAP_W'(PTR_ARB * OPR_CYC);
  localparam logic [GAP_W-1:0] PtrSlow     = GAP_W'(PTR_ARB * OPR_CYC * 2);
  localparam logic [GAP_W-1:0] DataPtrFast = GAP_W'(DATA_PTR_ARB * OPR_CYC);
  localparam logic [GAP_W-1:0] DataPtrSlow = GAP_W'(DATA_PTR_ARB * OPR_CYC * 2);

  logic [GAP_W-1:0] gap_q;
  reg_tag_e         prev_tag_q;
  reg_tag_e         cur_tag;
  logic [GAP_W-1:0] ptr_gap, data_ptr_gap, need;

  assign cur_tag = reg_tag_e'(cur_tag_i);

  // high-time counter, saturating; starts saturated so the first strobe is free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '1;
    end else if (ds_low_i) begin
      gap_q <= '0;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + GAP_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_tag_q <= TAG_OTHER;
    end else if (rise_i) begin
      prev_tag_q <= cur_tag;
    end
  end

  assign ptr_gap      = slow_arb_i ? PtrSlow : PtrFast;
  assign data_ptr_gap = slow_arb_i ? DataPtrSlow : DataPtrFast;

  always_comb begin
    need = HiGap;
    if (prev_tag_q == TAG_PTR_LO) begin
      if (ptr_gap > need) need = ptr_gap;
    end else if (prev_tag_q == TAG_DATA && cur_tag == TAG_PTR_LO) begin
      if (data_ptr_gap > need) need = data_ptr_gap;
    end
  end

  assign gap_ok_o = ({1'b0, gap_q} + (GAP_W+1)'(1)) >= {1'b0, need};

endmodule

// File: rtl/periph_wr_seq.sv
module periph_wr_seq import pwr_pkg::*; #(
  parameter int unsigned ADDR_W       = 3,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLK_NS       = 10,
  parameter int unsigned ADDR_SU_NS   = 105,
  parameter int unsigned ADDR_HD_NS   = 100,
  parameter int unsigned CS_SU_NS     = 50,
  parameter int unsigned DIR_SU_NS    = 10,
  parameter int unsigned DIR_HD_NS    = 10,
  parameter int unsigned DAT_SU_NS    = 30,
  parameter int unsigned DAT_HD_NS    = 10,
  parameter int unsigned DS_LO_NS     = 260,
  parameter int unsigned DS_HI_NS     = 230,
  parameter int unsigned OPR_CYC      = 4,
  parameter int unsigned PTR_ARB      = 4,
  parameter int unsigned DATA_PTR_ARB = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [1:0]        req_tag_i,
  input  logic              slow_arb_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_cs_n_o,
  output logic              bus_dir_o,
  output logic              bus_ds_n_o,
  output logic [DATA_W-1:0] bus_data_o
);

  localparam int unsigned SU_CYC = umax(1, umax(ns2cyc(ADDR_SU_NS, CLK_NS),
                                   umax(ns2cyc(CS_SU_NS, CLK_NS), ns2cyc(DIR_SU_NS, CLK_NS))));
  localparam int unsigned LO_CYC = umax(1, umax(ns2cyc(DS_LO_NS, CLK_NS), ns2cyc(DAT_SU_NS, CLK_NS)));
  localparam int unsigned HD_CYC = umax(1, umax(ns2cyc(ADDR_HD_NS, CLK_NS),
                                   umax(ns2cyc(DIR_HD_NS, CLK_NS), ns2cyc(DAT_HD_NS, CLK_NS))));
  localparam int unsigned HI_CYC = umax(1, ns2cyc(DS_HI_NS, CLK_NS));
  localparam int unsigned MAX_PH = umax(SU_CYC, umax(LO_CYC, HD_CYC));
  localparam int unsigned CNT_W  = $clog2(MAX_PH + 1);
  localparam int unsigned GAP_MX = umax(HI_CYC, 2 * OPR_CYC * umax(PTR_ARB, DATA_PTR_ARB));
  localparam int unsigned GAP_W  = $clog2(GAP_MX + 1);

  localparam logic [CNT_W-1:0] SuLim = CNT_W'(SU_CYC);
  localparam logic [CNT_W-1:0] LoLim = CNT_W'(LO_CYC);
  localparam logic [CNT_W-1:0] HdLim = CNT_W'(HD_CYC);

  phase_e           phase_q, phase_d;
  logic [1:0]       tag_q;
  logic [CNT_W-1:0] limit;
  logic             t_done, t_clr, gap_ok;
  logic             accept, fall_go, rise_go, hold_end;

  assign req_ready_o = (phase_q == PH_IDLE);
  assign accept      = req_ready_o && req_valid_i;
  assign fall_go     = (phase_q == PH_SETUP)  && t_done && gap_ok;
  assign rise_go     = (phase_q == PH_STROBE) && t_done;
  assign hold_end    = (phase_q == PH_HOLD)   && t_done;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (accept)   phase_d = PH_SETUP;
      PH_SETUP:  if (fall_go)  phase_d = PH_STROBE;
      PH_STROBE: if (rise_go)  phase_d = PH_HOLD;
      PH_HOLD:   if (hold_end) phase_d = PH_IDLE;
      default:                 phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (phase_q)
      PH_STROBE: limit = LoLim;
      PH_HOLD:   limit = HdLim;
      default:   limit = SuLim;
    endcase
  end

  assign t_clr = (phase_d != phase_q) || (phase_q == PH_IDLE);

  pwr_phase_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (t_clr),
    .limit_i (limit),
    .done_o  (t_done)
  );

  pwr_gap_tracker #(
    .HI_CYC       (HI_CYC),
    .OPR_CYC      (OPR_CYC),
    .PTR_ARB      (PTR_ARB),
    .DATA_PTR_ARB (DATA_PTR_ARB),
    .GAP_W        (GAP_W)
  ) u_gap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ds_low_i   (!bus_ds_n_o),
    .rise_i     (rise_go),
    .cur_tag_i  (tag_q),
    .slow_arb_i (slow_arb_i),
    .gap_ok_o   (gap_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_addr_o <= '0;
      bus_data_o <= '0;
      tag_q      <= '0;
      bus_cs_n_o <= 1'b1;
      bus_dir_o  <= 1'b0;
      bus_ds_n_o <= 1'b1;
    end else begin
      if (accept) begin
        bus_addr_o <= req_addr_i;
        bus_data_o <= req_data_i;
        tag_q      <= req_tag_i;
        bus_cs_n_o <= 1'b0;
        bus_dir_o  <= 1'b1;
      end
      if (fall_go) bus_ds_n_o <= 1'b0;
      if (rise_go) begin
        bus_ds_n_o <= 1'b1;
        bus_cs_n_o <= 1'b1;  // zero select hold
      end
      if (hold_end) bus_dir_o <= 1'b0;
    end
  end

endmodule

// File: rtl/pwr_checker.sv
module pwr_checker #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SU_CYC = 11,
  parameter int unsigned LO_CYC = 26,
  parameter int unsigned HI_CYC = 23
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_cs_n_o,
  input logic              bus_dir_o,
  input logic              bus_ds_n_o,
  input logic [DATA_W-1:0] bus_data_o
);

  logic [15:0] lo_cnt, hi_cnt, sel_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt  <= '0;
      hi_cnt  <= '1;
      sel_cnt <= '0;
    end else begin
      lo_cnt  <= bus_ds_n_o ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 16'd1);
      hi_cnt  <= !bus_ds_n_o ? '0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 16'd1);
      sel_cnt <= bus_cs_n_o ? '0 : ((sel_cnt == '1) ? sel_cnt : sel_cnt + 16'd1);
    end
  end

  assert_strobe_in_select_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_ds_n_o |-> !bus_cs_n_o);

  assert_dir_at_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_ds_n_o) |-> bus_dir_o);

  assert_setup_lead_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_ds_n_o) |-> (sel_cnt >= 16'(SU_CYC)));

  assert_low_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_ds_n_o) |-> (lo_cnt == 16'(LO_CYC)));

  assert_cs_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_ds_n_o) |-> bus_cs_n_o);

  assert_busy_on_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_ds_n_o |-> !req_ready_o);

  assert_high_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_ds_n_o) |-> (hi_cnt >= 16'(HI_CYC)));

  assert_stable_bus_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_cs_n_o && !$past(bus_cs_n_o)) |-> ($stable(bus_addr_o) && $stable(bus_data_o)));

endmodule

bind periph_wr_seq pwr_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .SU_CYC (SU_CYC),
  .LO_CYC (LO_CYC),
  .HI_CYC (HI_CYC)
) u_pwr_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .bus_addr_o  (bus_addr_o),
  .bus_cs_n_o  (bus_cs_n_o),
  .bus_dir_o   (bus_dir_o),
  .bus_ds_n_o  (bus_ds_n_o),
  .bus_data_o  (bus_data_o)
);

// File: tb/periph_wr_seq_test.sv
module periph_wr_seq_test;

  localparam int SU = 11;
  localparam int LO = 26;
  localparam int HD = 10;
  localparam int HI = 23;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic [1:0] req_tag = '0;
  logic       slow_arb = 1'b0;
  logic       ready, cs_n, dir, ds_n;
  logic [2:0] addr;
  logic [7:0] data;

  always #5 clk = ~clk;

  periph_wr_seq uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid),
    .req_ready_o (ready),
    .req_addr_i  (req_addr),
    .req_data_i  (req_data),
    .req_tag_i   (req_tag),
    .slow_arb_i  (slow_arb),
    .bus_addr_o  (addr),
    .bus_cs_n_o  (cs_n),
    .bus_dir_o   (dir),
    .bus_ds_n_o  (ds_n),
    .bus_data_o  (data)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // reference model state
  bit         have = 0;
  int         m_a, m_f, m_r, m_d;
  logic [2:0] m_addr;
  logic [7:0] m_data;
  int         last_rise = -1000;
  logic [1:0] last_tag = 2'b00;

  // observed timing
  logic prev_ds = 1'b1, prev_rdy = 1'b1;
  int   obs_acc = 0, obs_fall = 0, obs_rise = -1000;
  int   obs_gap = -1, obs_low = -1, obs_lead = -1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  function automatic bit model_busy();
    return have && (cyc < m_d);
  endfunction

  task automatic compare();
    bit e_ready, e_cs_n, e_ds_n, e_dir;
    e_ready = !model_busy();
    e_cs_n  = !(have && cyc >= m_a && cyc < m_r);
    e_ds_n  = !(have && cyc >= m_f && cyc < m_r);
    e_dir   = have && cyc >= m_a && cyc < m_d;
    check(ready == e_ready, "R2 ready", int'(ready), int'(e_ready));
    check(cs_n == e_cs_n, "R5 cs_n", int'(cs_n), int'(e_cs_n));
    check(ds_n == e_ds_n, "R4 ds_n", int'(ds_n), int'(e_ds_n));
    check(dir == e_dir, "R3 dir", int'(dir), int'(e_dir));
    if (e_dir) begin
      check(addr == m_addr, "R10 addr", int'(addr), int'(m_addr));
      check(data == m_data, "R10 data", int'(data), int'(m_data));
    end
    if (prev_rdy && !ready) obs_acc = cyc;
    if (prev_ds && !ds_n) begin
      obs_fall = cyc;
      obs_gap  = cyc - obs_rise;
      obs_lead = cyc - obs_acc;
    end
    if (!prev_ds && ds_n) begin
      obs_low  = cyc - obs_fall;
      obs_rise = cyc;
    end
    prev_ds  = ds_n;
    prev_rdy = ready;
  endtask

  task automatic step(output bit acc);
    int arb, need;
    acc = req_valid && !model_busy();
    if (acc) begin
      arb  = slow_arb ? 8 : 4;
      need = HI;
      if (last_tag == 2'b01) need = (4 * arb > need) ? 4 * arb : need;
      else if (last_tag == 2'b10 && req_tag == 2'b01) need = (5 * arb > need) ? 5 * arb : need;
      have   = 1;
      m_a    = cyc + 1;
      m_f    = (m_a + SU > last_rise + need) ? m_a + SU : last_rise + need;
      m_r    = m_f + LO;
      m_d    = m_r + HD;
      m_addr = req_addr;
      m_data = req_data;
      last_rise = m_r;
      last_tag  = req_tag;
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(acc);
  endtask

  task automatic send(input logic [2:0] a, input logic [7:0] d, input logic [1:0] t);
    bit acc;
    req_valid = 1'b1;
    req_addr  = a;
    req_data  = d;
    req_tag   = t;
    acc = 0;
    while (!acc) step(acc);
    req_valid = 1'b0;
    req_addr  = ~a;
    req_data  = ~d;
  endtask

  task automatic finish_txn();
    bit acc;
    while (model_busy()) step(acc);
  endtask

  task automatic expect_gap(input string req, input int exp);
    check(obs_gap == exp, req, obs_gap, exp);
    check(obs_low == LO, "R4 low width", obs_low, LO);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R1 ready", int'(ready), 1);
    check(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
    check(ds_n == 1'b1, "R1 ds_n", int'(ds_n), 1);
    check(dir == 1'b0, "R1 dir", int'(dir), 0);
    rst_ni = 1'b1;
    idle(4);

    // first cycle after reset: lead is pure setup
    send(3'd5, 8'hA5, 2'b00);
    finish_txn();
    check(obs_lead == SU, "R3 setup lead", obs_lead, SU);
    check(obs_low == LO, "R4 low width", obs_low, LO);

    // pointer-low offered right when ready returns, fast mode
    send(3'd1, 8'h3C, 2'b01);
    finish_txn();
    expect_gap("R6 floor gap", HI);

    // R7 slow: other after pointer-low
    slow_arb = 1'b1;
    send(3'd2, 8'h5A, 2'b00);
    finish_txn();
    expect_gap("R7 ptr slow gap", 32);

    // R9: data after other
    send(3'd0, 8'hC3, 2'b10);
    finish_txn();
    expect_gap("R9 data gap", HI);

    // R8: pointer-low after data, slow
    send(3'd1, 8'h81, 2'b01);
    finish_txn();
    expect_gap("R8 data-ptr slow gap", 40);

    // R7 fast: floor dominates
    slow_arb = 1'b0;
    send(3'd1, 8'h7E, 2'b01);
    finish_txn();
    expect_gap("R7 ptr fast gap", HI);

    // R9 spare tag after pointer-low in slow mode still honours R7
    slow_arb = 1'b1;
    send(3'd3, 8'h11, 2'b11);
    finish_txn();
    expect_gap("R7 ptr slow to spare", 32);

    // R9 spare tag adds nothing
    send(3'd6, 8'h22, 2'b01);
    finish_txn();
    expect_gap("R9 spare gap", HI);

    // R2 stall: second request waits behind the first
    slow_arb = 1'b0;
    send(3'd7, 8'hF0, 2'b10);
    send(3'd4, 8'h0F, 2'b00);
    finish_txn();
    expect_gap("R2 stalled gap", HI);
    check(obs_gap >= HI, "R6 stalled floor", obs_gap, HI);

    // R8 fast: floor dominates 20
    send(3'd2, 8'h99, 2'b10);
    finish_txn();
    send(3'd1, 8'h66, 2'b01);
    finish_txn();
    expect_gap("R8 data-ptr fast gap", HI);

    // long idle: lead back to setup only
    idle(60);
    send(3'd5, 8'h44, 2'b00);
    finish_txn();
    check(obs_lead == SU, "R3 lead after idle", obs_lead, SU);
    check(obs_gap > 40, "R6 idle gap", obs_gap, 41);
    idle(5);
    check(ready == 1'b1 && cs_n == 1'b1 && dir == 1'b0, "R5 idle bus",
          int'({ready, cs_n, dir}), 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog expired cyc=%0d actual=%0d expected=%0d", cyc, 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule